// File: doc/BRIEF.md
# Lockable Page Write/Erase Guard

This block decides, cycle by cycle, whether a page program or a page erase on a two-array non-volatile store may go ahead. One array holds device configuration. The other is a user data array. A requester presents a target array, a page number and an operation code. The block answers at once, in the same cycle, on a single allow line. Read requests are never refused.

Software sets protection through one byte register at word address E2h. The register has an enable bit and a two-bit range field. The range field protects an upper slice of the user array, and that slice grows in quarter steps. Bit 7 of the same byte is a one-way lock. Once it is set, the register is frozen, and only a power reset clears it.

The configuration array has fixed rules of its own:
- Its last page is a factory service page. It is never writable.
- Its second-to-last page holds protection settings. That page can be armed for locking, but the lock only takes effect at the next soft reset.

Every setting here is modelled as a flip-flop that the power reset clears. The soft reset leaves the register and the lock bit untouched.

Top module: `wprot_unit`

## Requirements
- R1: After power reset (`rst_n` low), the register at E2h reads 00h. Every program or erase is allowed, except those on the configuration service page.
- R2: While enable bit 2 is 0, every program and erase on the user array is allowed, whatever the range bits hold.
- R3: With enable = 1 and range bits [1:0] = 00, programs and erases on user pages 12 to 15 are denied, and those on pages 0 to 11 are allowed.
- R4: With enable = 1, the range value sets the lowest protected user page: 01 gives 8, 10 gives 4, 11 gives 0. Every page from that one up to page 15 is denied.
- R5: Writing E2h with bit 7 = 1 sets the lock. No later write and no soft reset clears it. Only `rst_n` does.
- R6: While the lock is set, a write to E2h is ignored, and the register keeps its previous value.
- R7: Reading at E2h returns {lock, 4'b0000, enable, range[1:0]}. Reading any other address returns 00h, and a write to any other address changes nothing.
- R8: Program and erase on configuration page 15 are always denied.
- R9: A pulse on `pp_lock_req` has no effect until a later cycle with `soft_rst` high. From then on, program and erase on configuration page 14 are denied.
- R10: Operation code 00 (read) is always allowed. Codes 01 (program), 10 (erase) and 11 (reserved) are all treated as modifying operations.
- R11: The software range never affects the configuration array. Configuration pages 0 to 13 are always allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power reset, clears all state |
| soft_rst | input | 1 | Soft reset pulse, promotes an armed page-14 lock |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address for both write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data at `reg_addr` (combinational) |
| pp_lock_req | input | 1 | Arms the protection-page lock |
| chk_region | input | 1 | Target array: 0 = configuration, 1 = user |
| chk_page | input | 4 | Target page number |
| chk_op | input | 2 | Operation: 00 read, 01 program, 10 erase, 11 reserved |
| chk_allow | output | 1 | 1 when the requested operation may proceed |

## Verification
The hardest case to reach is a protection-page lock that has been armed but not yet applied. The armed state cannot be read at any port. It shows only through page 14, which must stay open until a soft reset and then close. The stimulus therefore arms the lock, sweeps every page and operation, and only then pulses `soft_rst` and sweeps again.

A second hard case is the single write that both loads new range bits and sets the lock in the same cycle. That write is followed by attempts to rewrite the register and by a soft reset. Readback at E2h and the allow line must both show that nothing moved.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_PROG  = 2'b01,
    OP_ERASE = 2'b10,
    OP_RSVD  = 2'b11
  } op_e;

  typedef struct packed {
    logic       lock;
    logic       en;
    logic [1:0] rng;
  } wp_state_t;

  localparam logic [7:0] WP_REG_ADDR = 8'hE2;
endpackage

// File: rtl/wprot_reg.sv
module wprot_reg
  import wprot_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] REG_ADDR = AW'(WP_REG_ADDR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output wp_state_t     st
);
  localparam int LOCK_BIT = DW - 1;

  wp_state_t st_q;
  logic      hit;
  logic      unused_wbits;

  assign hit          = (addr == REG_ADDR);
  assign unused_wbits = ^wdata[LOCK_BIT-1:3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else if (wr && hit && !st_q.lock) begin
      st_q.en   <= wdata[2];
      st_q.rng  <= wdata[1:0];
      st_q.lock <= wdata[LOCK_BIT];
    end
  end

  always_comb begin
    rdata = '0;
    if (hit) begin
      rdata[LOCK_BIT] = st_q.lock;
      rdata[2]        = st_q.en;
      rdata[1:0]      = st_q.rng;
    end
  end

  assign st = st_q;

  // R5: the lock never drops while power reset is inactive
  p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st_q.lock |=> st_q.lock);

  // R6: once locked, the register contents stay frozen
  p_locked_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st_q.lock |=> $stable({st_q.en, st_q.rng}));
endmodule

// File: rtl/wprot_range.sv
module wprot_range #(
  parameter int PAGE_W = 4
) (
  input  logic              en,
  input  logic [1:0]        rng,
  input  logic [PAGE_W-1:0] page,
  output logic              hit
);
  localparam int PAGES = 1 << PAGE_W;
  localparam int QTR   = PAGES / 4;

  logic [3:0] lvl_hit;

  for (genvar g = 0; g < 4; g++) begin : g_lvl
    if (g == 3) begin : g_all
      assign lvl_hit[g] = 1'b1;
    end else begin : g_cmp
      localparam logic [PAGE_W-1:0] FLOOR = PAGE_W'((3 - g) * QTR);
      assign lvl_hit[g] = (page >= FLOOR);
    end
  end

  assign hit = en & lvl_hit[rng];
endmodule

// File: rtl/wprot_pages.sv
module wprot_pages (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic arm,
  output logic pp_locked
);
  logic armed_q;
  logic active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      active_q <= 1'b0;
    end else begin
      if (arm)      armed_q  <= 1'b1;
      if (soft_rst) active_q <= armed_q;
    end
  end

  assign pp_locked = active_q;

  // R9: the page-14 lock only becomes active on a soft reset
  p_deferred_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && !active_q) |=> !active_q);
endmodule

// File: rtl/wprot_unit.sv
module wprot_unit
  import wprot_pkg::*;
#(
  parameter int PAGE_W = 4,
  parameter int AW     = 8,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              pp_lock_req,
  input  logic              chk_region,
  input  logic [PAGE_W-1:0] chk_page,
  input  logic [1:0]        chk_op,
  output logic              chk_allow
);
  localparam logic [PAGE_W-1:0] SVC_PAGE  = PAGE_W'((1 << PAGE_W) - 1);
  localparam logic [PAGE_W-1:0] PROT_PAGE = PAGE_W'((1 << PAGE_W) - 2);

  wp_state_t st;
  logic      range_hit;
  logic      pp_locked;
  logic      modify;
  logic      cfg_deny;

  wprot_reg #(.AW(AW), .DW(DW)) i_reg (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .st(st)
  );

  wprot_range #(.PAGE_W(PAGE_W)) i_range (
    .en(st.en), .rng(st.rng), .page(chk_page), .hit(range_hit)
  );

  wprot_pages i_pages (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .arm(pp_lock_req), .pp_locked(pp_locked)
  );

  assign modify   = (chk_op != OP_READ);
  assign cfg_deny = (chk_page == SVC_PAGE) || (pp_locked && chk_page == PROT_PAGE);

  always_comb begin
    if (!modify)         chk_allow = 1'b1;
    else if (chk_region) chk_allow = !range_hit;
    else                 chk_allow = !cfg_deny;
  end

  // R8: the service page is never modifiable
  p_svc_page_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!chk_region && chk_page == SVC_PAGE && chk_op != OP_READ) |-> !chk_allow);

  // R10: reads are always allowed
  p_read_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_op == OP_READ) |-> chk_allow);

  // R2: with protection disabled the user array is open
  p_disabled_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_region && !st.en) |-> chk_allow);

  // R11: low configuration pages are never blocked by software range
  p_cfg_low_open_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!chk_region && chk_page < PROT_PAGE) |-> chk_allow);
endmodule

// File: tb/test_wprot_unit.sv
module test_wprot_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'hE2;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       pp_lock_req = 1'b0;
  logic       chk_region = 1'b0;
  logic [3:0] chk_page = 4'd0;
  logic [1:0] chk_op = 2'b00;
  logic       chk_allow;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural model state
  bit       m_lock, m_en, m_armed, m_act;
  bit [1:0] m_rng;

  always #5 clk = ~clk;

  wprot_unit i_wprot_unit (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pp_lock_req(pp_lock_req), .chk_region(chk_region), .chk_page(chk_page),
    .chk_op(chk_op), .chk_allow(chk_allow)
  );

  function automatic bit m_allow(bit reg_sel, int pg, int op);
    if (op == 0) return 1;
    if (!reg_sel) begin
      if (pg == 15) return 0;
      if (pg == 14 && m_act) return 0;
      return 1;
    end
    if (!m_en) return 1;
    return (pg < (3 - m_rng) * 4);
  endfunction

  function automatic string m_tag(bit reg_sel, int pg, int op);
    if (op == 0) return "R10";
    if (!reg_sel) begin
      if (pg == 15) return "R8";
      if (pg == 14) return "R9";
      return "R11";
    end
    if (!m_en) return "R2";
    if (m_rng == 0) return "R3";
    return "R4";
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit wr, bit [7:0] a, bit [7:0] d, bit arm, bit srst,
                      bit reg_sel, bit [3:0] pg, bit [1:0] op, string rtag);
    bit [7:0] exp_rd;
    reg_wr = wr; reg_addr = a; reg_wdata = d; pp_lock_req = arm;
    soft_rst = srst; chk_region = reg_sel; chk_page = pg; chk_op = op;
    #2;
    exp_rd = (a == 8'hE2) ? {m_lock, 4'b0000, m_en, m_rng} : 8'h00;
    check(m_tag(reg_sel, pg, op), chk_allow, m_allow(reg_sel, pg, op));
    check(rtag, reg_rdata, exp_rd);
    @(posedge clk);
    if (wr && a == 8'hE2 && !m_lock) begin
      m_en = d[2]; m_rng = d[1:0]; m_lock = d[7];
    end
    if (srst) m_act = m_armed;
    if (arm) m_armed = 1;
    @(negedge clk);
    reg_wr = 0; pp_lock_req = 0; soft_rst = 0;
  endtask

  task automatic sweep(string rtag);
    for (int r = 0; r < 2; r++)
      for (int p = 0; p < 16; p++)
        for (int o = 0; o < 4; o++)
          step(0, 8'hE2, 8'h00, 0, 0, r[0], p[3:0], o[1:0], rtag);
  endtask

  task automatic wr_reg(bit [7:0] a, bit [7:0] d, string rtag);
    step(1, a, d, 0, 0, 1, 4'd15, 2'b01, rtag);
  endtask

  initial begin
    m_lock = 0; m_en = 0; m_armed = 0; m_act = 0; m_rng = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #2;
    check("R1", reg_rdata, 8'h00);
    check("R1", chk_allow, 1);
    sweep("R1");
    wr_reg(8'hE2, 8'h03, "R7");          // range set, enable off
    sweep("R2");
    wr_reg(8'hE2, 8'h04, "R7");
    sweep("R3");
    wr_reg(8'hE2, 8'h05, "R7");
    sweep("R4");
    wr_reg(8'hE2, 8'h06, "R7");
    sweep("R4");
    wr_reg(8'hE2, 8'h07, "R7");
    sweep("R4");
    wr_reg(8'h10, 8'h80, "R7");          // other address: no effect
    step(0, 8'h10, 8'h00, 0, 0, 1, 4'd3, 2'b10, "R7");
    step(0, 8'hE2, 8'h00, 1, 0, 0, 4'd14, 2'b01, "R9");  // arm
    sweep("R9");
    step(0, 8'hE2, 8'h00, 0, 1, 0, 4'd14, 2'b10, "R9");  // soft reset
    sweep("R9");
    wr_reg(8'hE2, 8'h85, "R5");          // load and lock together
    wr_reg(8'hE2, 8'h00, "R6");
    wr_reg(8'hE2, 8'h04, "R6");
    step(0, 8'hE2, 8'h00, 0, 1, 1, 4'd8, 2'b01, "R5");
    step(0, 8'hE2, 8'h00, 0, 0, 1, 4'd7, 2'b01, "R6");
    sweep("R6");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule